// File: doc/BRIEF.md
# Multi-bank interrupt control unit

This block collects a large set of level or pulse interrupt sources from peripherals and presents them to a processor as a small number of request lines. The sources are grouped into banks of equal width. Every bank keeps a latched pending word, an enable word and a masked view of the two. It raises its own request output whenever any pending and enabled source is present.

Software reaches the banks through a plain single-cycle register port. The port carries a byte address, a write strobe, a read strobe and 32-bit data. Each bank owns a window of five word registers, and the windows repeat at a fixed stride. Pending bits are acknowledged by writing ones to the pending register. Software can also raise a pending bit itself through a set register. A read returns its data on the clock edge that samples the read strobe and holds it until the next read. Reset leaves every source blocked until software enables it.

Top module: `icu_multibank`

## Requirements
- R1: After reset every pending word, every enable word and every request output is zero. The pending, enable and masked registers read zero, and the inverted-enable register reads all ones.
- R2: Source input n belongs to bank n/32 at bit n%32. Bank k's window starts at byte address k*0x28, with pending at +0x00, enable at +0x08, masked at +0x10, set at +0x18 and inverted-enable at +0x20.
- R3: A source input sampled at 1 on a clock edge sets its pending bit at that edge. The bit stays set after the source returns to 0.
- R4: Writing to the pending register clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R5: When a source is 1 on the same edge that a write-one-to-clear targets its bit, the bit stays set.
- R6: The enable register is read/write as a whole word. A write replaces all of its bits.
- R7: The masked register reads as pending AND enable. Writes to it change nothing.
- R8: Writing to the set register ORs the written data into the pending word. The set register reads as zero.
- R9: The inverted-enable register reads as the bitwise inverse of the enable word. Writes to it change nothing.
- R10: Request output k is 1 exactly one cycle after bank k's masked word is non-zero. It returns to 0 one cycle after the masked word becomes zero, for example after an acknowledge.
- R11: Addresses that fall in no register read as zero and writes to them change no state. This covers unlisted offsets inside a window and addresses past the last bank.
- R12: A read strobe sampled at an edge loads that cycle's register value into the read data output at the same edge. The read data output keeps its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 8 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_src_i | input | 160 | Peripheral interrupt sources, bank-major |
| irq_req_o | output | 5 | One request line per bank |

## Verification
A register write or a source pulse takes effect at the edge that samples it. A read strobed at an edge shows its data after that edge, so the bench compares it at the next falling edge. A request output trails the masked word by one register, so the bench waits one further falling edge after any state change before it compares the request vector. The bench's read driver pushes the expected word into a queue when it strobes. A monitor pops and compares that word exactly one edge later, so every comparison lands in the cycle the result is due.

// File: rtl/icu_pkg.sv
package icu_pkg;

    // Register offsets inside one bank window. The bank's behaviour
    // depends on these values, so they are fixed here.
    localparam int OFF_PEND = 'h00;
    localparam int OFF_EN   = 'h08;
    localparam int OFF_MASK = 'h10;
    localparam int OFF_SET  = 'h18;
    localparam int OFF_INV  = 'h20;

    typedef enum logic [2:0] {
        REG_PEND = 3'd0,
        REG_EN   = 3'd1,
        REG_MASK = 3'd2,
        REG_SET  = 3'd3,
        REG_INV  = 3'd4,
        REG_NONE = 3'd7
    } icu_reg_e;

endpackage

// File: rtl/icu_addr_decode.sv
module icu_addr_decode
    import icu_pkg::*;
#(
    parameter int NUM_BANKS   = 5,
    parameter int ADDR_W      = 8,
    parameter int BANK_STRIDE = 'h28
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_BANKS-1:0] bank_hit_o,
    output icu_reg_e             reg_sel_o
);

    logic [ADDR_W-1:0] off_part [NUM_BANKS];
    logic [ADDR_W-1:0] offset;

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_win
        localparam int BASE = k * BANK_STRIDE;
        localparam logic [ADDR_W-1:0] BASE_V = BASE[ADDR_W-1:0];
        assign bank_hit_o[k] = (int'(addr_i) >= BASE) &&
                               (int'(addr_i) < BASE + BANK_STRIDE);
        assign off_part[k]   = bank_hit_o[k] ? (addr_i - BASE_V) : '0;
    end

    always_comb begin
        offset = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            offset = offset | off_part[k];
        end
    end

    always_comb begin
        reg_sel_o = REG_NONE;
        if (bank_hit_o != '0) begin
            case (int'(offset))
                OFF_PEND: reg_sel_o = REG_PEND;
                OFF_EN:   reg_sel_o = REG_EN;
                OFF_MASK: reg_sel_o = REG_MASK;
                OFF_SET:  reg_sel_o = REG_SET;
                OFF_INV:  reg_sel_o = REG_INV;
                default:  reg_sel_o = REG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/icu_bank.sv
module icu_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_i,
    input  logic             clr_we_i,
    input  logic             en_we_i,
    input  logic             set_we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] pend_o,
    output logic [WIDTH-1:0] en_o,
    output logic [WIDTH-1:0] masked_o,
    output logic             req_o
);

    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] en_q;
    logic [WIDTH-1:0] clr_mask;
    logic [WIDTH-1:0] set_mask;
    logic [WIDTH-1:0] pend_d;
    logic             req_q;

    // Sources and software set are ORed in after the clear, so a set wins.
    always_comb begin
        clr_mask = clr_we_i ? wdata_i : '0;
        set_mask = set_we_i ? wdata_i : '0;
        pend_d   = (pend_q & ~clr_mask) | set_mask | src_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= pend_d;
            if (en_we_i) begin
                en_q <= wdata_i;
            end
        end
    end

    assign masked_o = pend_q & en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= |masked_o;
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign req_o  = req_q;

    // R3
    src_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((pend_o & $past(src_i)) == $past(src_i)));

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !set_we_i) |=> ((pend_o & $past(wdata_i & ~src_i)) == '0));

    // R4
    w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !set_we_i) |=>
        ((pend_o & ~$past(wdata_i) & ~$past(src_i)) ==
         ($past(pend_o) & ~$past(wdata_i) & ~$past(src_i))));

    // R6
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> (en_o == $past(wdata_i)));

    // R10
    req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_o != '0) |=> req_o);

    // R10
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_o == '0) |=> !req_o);

endmodule

// File: rtl/icu_multibank.sv
module icu_multibank
    import icu_pkg::*;
#(
    parameter int NUM_BANKS   = 5,
    parameter int BANK_WIDTH  = 32,
    parameter int ADDR_W      = 8,
    parameter int BANK_STRIDE = 'h28
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               bus_addr_i,
    input  logic                            bus_wr_i,
    input  logic                            bus_rd_i,
    input  logic [BANK_WIDTH-1:0]           bus_wdata_i,
    output logic [BANK_WIDTH-1:0]           bus_rdata_o,
    input  logic [NUM_BANKS*BANK_WIDTH-1:0] irq_src_i,
    output logic [NUM_BANKS-1:0]            irq_req_o
);

    logic [NUM_BANKS-1:0]  bank_hit;
    icu_reg_e              reg_sel;
    logic [BANK_WIDTH-1:0] pend_w   [NUM_BANKS];
    logic [BANK_WIDTH-1:0] en_w     [NUM_BANKS];
    logic [BANK_WIDTH-1:0] masked_w [NUM_BANKS];
    logic [BANK_WIDTH-1:0] rd_val;
    logic [BANK_WIDTH-1:0] rdata_q;

    icu_addr_decode #(
        .NUM_BANKS  (NUM_BANKS),
        .ADDR_W     (ADDR_W),
        .BANK_STRIDE(BANK_STRIDE)
    ) u_dec (
        .addr_i    (bus_addr_i),
        .bank_hit_o(bank_hit),
        .reg_sel_o (reg_sel)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        logic wr_hit;
        assign wr_hit = bus_wr_i && bank_hit[k];

        icu_bank #(
            .WIDTH(BANK_WIDTH)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (irq_src_i[k*BANK_WIDTH +: BANK_WIDTH]),
            .clr_we_i(wr_hit && (reg_sel == REG_PEND)),
            .en_we_i (wr_hit && (reg_sel == REG_EN)),
            .set_we_i(wr_hit && (reg_sel == REG_SET)),
            .wdata_i (bus_wdata_i),
            .pend_o  (pend_w[k]),
            .en_o    (en_w[k]),
            .masked_o(masked_w[k]),
            .req_o   (irq_req_o[k])
        );
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (bank_hit[k]) begin
                case (reg_sel)
                    REG_PEND: rd_val = pend_w[k];
                    REG_EN:   rd_val = en_w[k];
                    REG_MASK: rd_val = masked_w[k];
                    REG_INV:  rd_val = ~en_w[k];
                    default:  rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd_i) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata_o = rdata_q;

    // R2
    bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_hit));

    // R11
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && (reg_sel == REG_NONE)) |=> (bus_rdata_o == '0));

    // R8
    set_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && (reg_sel == REG_SET)) |=> (bus_rdata_o == '0));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o));

endmodule

// File: tb/icu_multibank_tb_top.sv
`timescale 1ns/1ps
module icu_multibank_tb_top;

    localparam int NB = 5;
    localparam int BW = 32;
    localparam int STRIDE = 40;

    typedef struct {
        logic [31:0] exp;
        string       tag;
        int          addr;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NB*BW-1:0] irq_src = '0;
    logic [NB-1:0] irq_req;

    logic [31:0] m_pend [NB];
    logic [31:0] m_en   [NB];
    sb_item_t    sb_q [$];
    logic        rd_seen = 1'b0;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    icu_multibank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr_i (bus_addr),
        .bus_wr_i   (bus_wr),
        .bus_rd_i   (bus_rd),
        .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata),
        .irq_src_i  (irq_src),
        .irq_req_o  (irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int a);
        int k;
        int o;
        if (a >= NB * STRIDE) return '0;
        k = a / STRIDE;
        o = a % STRIDE;
        case (o)
            'h00: return m_pend[k];
            'h08: return m_en[k];
            'h10: return m_pend[k] & m_en[k];
            'h20: return ~m_en[k];
            default: return '0;
        endcase
    endfunction

    task automatic model_write(input int a, input logic [31:0] d);
        int k;
        int o;
        if (a < NB * STRIDE) begin
            k = a / STRIDE;
            o = a % STRIDE;
            case (o)
                'h00: m_pend[k] = m_pend[k] & ~d;
                'h08: m_en[k] = d;
                'h18: m_pend[k] = m_pend[k] | d;
                default: ;
            endcase
        end
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a[7:0];
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    // Driver: strobe a read and push the expected word into the scoreboard.
    task automatic do_read(input int a, input string tag);
        @(negedge clk);
        bus_addr = a[7:0];
        bus_rd = 1'b1;
        sb_q.push_back('{exp: exp_read(a), tag: tag, addr: a});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_src(input int n);
        @(negedge clk);
        irq_src[n] = 1'b1;
        @(negedge clk);
        irq_src[n] = 1'b0;
        m_pend[n / BW][n % BW] = 1'b1;
    endtask

    task automatic chk_req(input string tag);
        logic [NB-1:0] exp;
        @(negedge clk);
        for (int k = 0; k < NB; k++) exp[k] = |(m_pend[k] & m_en[k]);
        check(tag, 32'(irq_req), 32'(exp));
    endtask

    // Monitor: the read strobed at an edge is due after that edge.
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            sb_item_t it;
            if (sb_q.size() == 0) begin
                check("R12 unexpected read data", bus_rdata, 32'hx);
            end else begin
                it = sb_q.pop_front();
                check($sformatf("%s @%0h", it.tag, it.addr), bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NB; k++) begin
            m_pend[k] = '0;
            m_en[k] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every bank
        check("R1 request after reset", 32'(irq_req), 32'h0);
        for (int k = 0; k < NB; k++) begin
            do_read(k*STRIDE + 'h00, "R1 pending after reset");
            do_read(k*STRIDE + 'h08, "R1 enable after reset");
            do_read(k*STRIDE + 'h10, "R1 masked after reset");
            do_read(k*STRIDE + 'h20, "R1 inverted enable after reset");
        end

        for (int k = 0; k < NB; k++) begin
            int b;
            int bit_a;
            b = k * STRIDE;
            bit_a = k * 5 + 3;
            pulse_src(k*BW + bit_a);
            pulse_src(k*BW + 31);
            do_read(b + 'h00, "R2 R3 latched pending");
            do_read(b + 'h10, "R7 masked while disabled");
            chk_req("R10 no request while disabled");
            do_write(b + 'h08, (32'(1) << bit_a) | 32'h8000_0000);
            chk_req("R10 request after enable");
            do_read(b + 'h08, "R6 enable readback");
            do_read(b + 'h10, "R7 masked readback");
            do_read(b + 'h20, "R9 inverted enable");
            do_write(b + 'h10, 32'hFFFF_FFFF);
            do_write(b + 'h20, 32'h0);
            do_read(b + 'h08, "R7 R9 writes ignored enable");
            do_read(b + 'h00, "R7 R9 writes ignored pending");
            do_write(b + 'h00, 32'(1) << bit_a);
            do_read(b + 'h00, "R4 partial clear");
            chk_req("R10 request held by other bit");
            do_write(b + 'h00, 32'h8000_0000);
            do_read(b + 'h00, "R4 all cleared");
            chk_req("R10 request drops after acknowledge");
            do_write(b + 'h18, 32'h0000_0020);
            do_read(b + 'h00, "R8 software set");
            do_read(b + 'h18, "R8 set register reads zero");
            do_write(b + 'h08, 32'h0000_0020);
            chk_req("R10 request from software set");
            do_write(b + 'h00, 32'h0000_0020);
            do_write(b + 'h08, 32'h0);
            chk_req("R10 request idle after cleanup");
        end

        // R5: source and clear on the same edge
        @(negedge clk);
        irq_src[3] = 1'b1;
        bus_addr = 8'h00;
        bus_wdata = 32'h8;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        irq_src[3] = 1'b0;
        m_pend[0] = m_pend[0] | 32'h8;
        do_read('h00, "R5 set wins over clear");

        // R11: unmapped addresses
        do_write('h08, 32'h0000_00F0);
        do_write('h04, 32'hFFFF_FFFF);
        do_write('h24, 32'hFFFF_FFFF);
        do_write('hC8, 32'hFFFF_FFFF);
        do_write('hAC, 32'hFFFF_FFFF);
        do_read('h04, "R11 gap offset reads zero");
        do_read('h24, "R11 window tail reads zero");
        do_read('hC8, "R11 past last bank reads zero");
        do_read('hFF, "R11 top address reads zero");
        do_read('h00, "R11 pending untouched");
        do_read('h08, "R11 enable untouched");
        do_read(4*STRIDE + 'h08, "R11 last bank enable untouched");
        chk_req("R11 R10 no stray request");

        // R12: data holds with no read strobe
        do_read('h20, "R12 read data due");
        repeat (3) @(negedge clk);
        check("R12 read data held", bus_rdata, ~32'h0000_00F0);

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule